// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a microcontroller bus and an on-chip flash array. It watches bus writes and decodes multi-byte command sequences. Every command starts with a fixed two-write unlock preamble that checks both address and data. The decoder then acts on the command byte that follows. It either changes the read mode of the flash or issues a one-cycle start pulse to the program, erase, suspend, resume or bypass machinery. That machinery is outside this block.

Reads normally return array contents. After the special-read command, reads at two particular address patterns return something else: the device identifier, or the protection bit of the selected sector. Any other address returns zero in that mode. A wrong byte, a wrong address, or a pause between bytes that exceeds a tick-counted limit drops the decoder back to plain array reads.

The write strobe is synchronised and edge-detected inside the block. A slow bus that holds the strobe for many clocks is therefore decoded once per write.

Top module: `fcmd_decoder`

## Requirements
- R1: After synchronous reset, `rd_src_o` is 0 (array source), `rd_data_o` is 00h and all start pulses are low.
- R2: A command is accepted only after an unlock preamble: first a write of AAh at address 555h, then a write of 55h at address AAAh. The third write carries the command byte.
- R3: A write with every sector-select line low is ignored: it neither advances nor breaks a pending sequence.
- R4: A write that does not match the expected next step abandons the sequence and leaves special-read mode. A lone write other than the first unlock step does the same.
- R5: With a sequence pending, the sequence is abandoned and array-read mode is restored when `TIMEOUT_TICKS` tick pulses arrive without an accepted write. `TIMEOUT_TICKS`-1 ticks do not abandon it.
- R6: Byte F0h forces array-read mode, whether written alone or as the command byte after the preamble.
- R7: Command byte 90h enters special-read mode. The mode persists across any number of reads until a reset command or a broken sequence.
- R8: In special-read mode, a read with {A6,A1,A0}=001 and a primary select high returns `dev_id_i` with `rd_src_o`=1. With only secondary selects high, the same read returns 00h with `rd_src_o`=3.
- R9: In special-read mode, a read with {A6,A1,A0}=010 returns 01h or 00h with `rd_src_o`=2. The value is the protection bit of the lowest-indexed high select. Primary select i maps to `prot_vec_i[i]` and secondary select j maps to `prot_vec_i[N_PRI+j]`.
- R10: In special-read mode, any other read address returns 00h with `rd_src_o`=3. In array-read mode every read returns `array_data_i` with `rd_src_o`=0.
- R11: `rd_src_o` and `rd_data_o` are registered one clock after a cycle with `rd_strobe_i` high, and they hold while `rd_strobe_i` is low.
- R12: Command bytes after the preamble give single-cycle pulses: A0h arms program and the next write pulses `prog_start_o`; B0h gives suspend; 30h gives resume; 20h gives bypass. `tgt_sec_o` shows whether any secondary select was high at the completing write.
- R13: Command byte 80h followed by AAh@555h, 55h@AAAh, then 30h or 10h pulses `erase_start_o`, with `erase_chip_o` 0 for 30h (sector) and 1 for 10h (chip).
- R14: A write strobe held high for many clocks is decoded exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 12 | Low bus address A11..A0 |
| bus_data_i | input | 8 | Bus write data |
| wr_strobe_i | input | 1 | Write strobe, active high, asynchronous to clk |
| rd_strobe_i | input | 1 | Read strobe, active high |
| sel_pri_i | input | N_PRI | Primary sector selects |
| sel_sec_i | input | N_SEC | Secondary sector selects |
| prot_vec_i | input | N_PRI+N_SEC | Per-sector protection bits |
| dev_id_i | input | 8 | Device identifier byte |
| array_data_i | input | 8 | Data read from the flash array |
| tick_i | input | 1 | Free-running time-base pulse |
| rd_src_o | output | 2 | Read source: 0 array, 1 id, 2 protection, 3 zero |
| rd_data_o | output | 8 | Registered read data |
| prog_start_o | output | 1 | Program start pulse |
| erase_start_o | output | 1 | Erase start pulse |
| erase_chip_o | output | 1 | Last erase was a whole-chip erase |
| suspend_o | output | 1 | Erase suspend pulse |
| resume_o | output | 1 | Erase resume pulse |
| bypass_o | output | 1 | Bypass command pulse |
| tgt_sec_o | output | 1 | Last command targeted the secondary array |

## Verification
Some properties are checked on every cycle. The start pulses are never high together and each lasts one cycle. The edge detector fires once per strobe. Writes without a select leave the sequence state untouched. An expired timer returns the decoder to idle in array mode. The read register holds while the strobe is low. The tick counter stays below its limit.

Other behaviour can only be shown by the bench's directed scenarios. These cover whether a given byte and address sequence reaches the right mode or pulse. They also cover the exact timer boundary and the values returned for each read address pattern.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM, SQ_ERA1, SQ_ERA2, SQ_ERA3
  } seq_e;

  typedef enum logic [1:0] {
    SRC_ARRAY = 2'd0, SRC_ID = 2'd1, SRC_PROT = 2'd2, SRC_ZERO = 2'd3
  } rd_src_e;

  localparam logic [11:0] UNL_ADDR1 = 12'h555;
  localparam logic [11:0] UNL_ADDR2 = 12'hAAA;
  localparam logic [7:0]  UNL_DATA1 = 8'hAA;
  localparam logic [7:0]  UNL_DATA2 = 8'h55;
  localparam logic [7:0]  CMD_RESET   = 8'hF0;
  localparam logic [7:0]  CMD_SPECIAL = 8'h90;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_ERASE   = 8'h80;
  localparam logic [7:0]  CMD_SUSP    = 8'hB0;
  localparam logic [7:0]  CMD_RESUME  = 8'h30;
  localparam logic [7:0]  CMD_BYPASS  = 8'h20;
  localparam logic [7:0]  CFM_SECTOR  = 8'h30;
  localparam logic [7:0]  CFM_CHIP    = 8'h10;
endpackage

// File: rtl/fcmd_wr_edge.sv
module fcmd_wr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic edge_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], strobe_i};
  end

  assign edge_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  a_r14_edge_single: assert property (@(posedge clk) disable iff (rst)
    edge_o |=> !edge_o);
endmodule

// File: rtl/fcmd_timer.sv
module fcmd_timer #(
  parameter int TIMEOUT_TICKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic timeout_o
);
  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i || !busy_i) cnt_q <= '0;
    else if (tick_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign timeout_o = busy_i & tick_i & ~restart_i & (cnt_q == LAST);

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_i,
  input  logic        any_sel_i,
  input  logic        any_sec_i,
  input  logic [11:0] addr_i,
  input  logic [7:0]  data_i,
  input  logic        timeout_i,
  output logic        busy_o,
  output logic        accept_o,
  output logic        special_o,
  output logic        prog_o,
  output logic        erase_o,
  output logic        erase_chip_o,
  output logic        susp_o,
  output logic        resume_o,
  output logic        bypass_o,
  output logic        tgt_sec_o
);
  seq_e seq_q, seq_d;
  logic spec_q, spec_d;
  logic p_prog, p_erase, p_susp, p_res, p_byp, chip_d;
  logic wr_ok, is_unl1, is_unl2;

  assign wr_ok   = wr_i & any_sel_i;
  assign is_unl1 = (addr_i == UNL_ADDR1) && (data_i == UNL_DATA1);
  assign is_unl2 = (addr_i == UNL_ADDR2) && (data_i == UNL_DATA2);

  always_comb begin
    seq_d = seq_q; spec_d = spec_q;
    p_prog = 1'b0; p_erase = 1'b0; p_susp = 1'b0; p_res = 1'b0; p_byp = 1'b0;
    chip_d = erase_chip_o;
    if (wr_ok) begin
      seq_d = SQ_IDLE;
      case (seq_q)
        SQ_IDLE: if (is_unl1) seq_d = SQ_UNL1; else spec_d = 1'b0;
        SQ_UNL1: if (is_unl2) seq_d = SQ_UNL2; else spec_d = 1'b0;
        SQ_UNL2: begin
          case (data_i)
            CMD_SPECIAL: spec_d = 1'b1;
            CMD_PROG:    seq_d = SQ_PGM;
            CMD_ERASE:   seq_d = SQ_ERA1;
            CMD_SUSP:    p_susp = 1'b1;
            CMD_RESUME:  p_res = 1'b1;
            CMD_BYPASS:  p_byp = 1'b1;
            default:     spec_d = 1'b0;
          endcase
        end
        SQ_PGM:  p_prog = 1'b1;
        SQ_ERA1: if (is_unl1) seq_d = SQ_ERA2; else spec_d = 1'b0;
        SQ_ERA2: if (is_unl2) seq_d = SQ_ERA3; else spec_d = 1'b0;
        SQ_ERA3: begin
          if (data_i == CFM_SECTOR) begin p_erase = 1'b1; chip_d = 1'b0; end
          else if (data_i == CFM_CHIP) begin p_erase = 1'b1; chip_d = 1'b1; end
          else spec_d = 1'b0;
        end
        default: spec_d = 1'b0;
      endcase
    end else if (timeout_i) begin
      seq_d  = SQ_IDLE;
      spec_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= SQ_IDLE; spec_q <= 1'b0;
      prog_o <= 1'b0; erase_o <= 1'b0; susp_o <= 1'b0; resume_o <= 1'b0;
      bypass_o <= 1'b0; erase_chip_o <= 1'b0; tgt_sec_o <= 1'b0;
    end else begin
      seq_q <= seq_d; spec_q <= spec_d;
      prog_o <= p_prog; erase_o <= p_erase; susp_o <= p_susp;
      resume_o <= p_res; bypass_o <= p_byp; erase_chip_o <= chip_d;
      if (p_prog | p_erase | p_susp | p_res | p_byp) tgt_sec_o <= any_sec_i;
    end
  end

  assign busy_o    = (seq_q != SQ_IDLE);
  assign accept_o  = wr_ok;
  assign special_o = spec_q;

  a_r12_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_o, erase_o, susp_o, resume_o, bypass_o}));
  a_r12_prog_one_cycle: assert property (@(posedge clk) disable iff (rst)
    prog_o |=> !prog_o);
  a_r13_erase_one_cycle: assert property (@(posedge clk) disable iff (rst)
    erase_o |=> !erase_o);
  a_r3_nosel_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !any_sel_i && !timeout_i) |=> ($stable(seq_q) && $stable(spec_q)));
  a_r5_timeout_idle: assert property (@(posedge clk) disable iff (rst)
    (timeout_i && !wr_ok) |=> (seq_q == SQ_IDLE && !spec_q));
endmodule

// File: rtl/fcmd_rd_mux.sv
module fcmd_rd_mux
  import fcmd_pkg::*;
#(
  parameter int N_SEL = 12,
  parameter int N_PRI = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_strobe_i,
  input  logic             special_i,
  input  logic [2:0]       key_i,
  input  logic [N_SEL-1:0] sel_all_i,
  input  logic [N_SEL-1:0] prot_vec_i,
  input  logic [7:0]       dev_id_i,
  input  logic [7:0]       array_data_i,
  output logic [1:0]       src_o,
  output logic [7:0]       data_o
);
  rd_src_e src_d;
  logic [7:0] data_d;
  logic pbit, any_pri;

  assign any_pri = |sel_all_i[N_PRI-1:0];

  always_comb begin
    pbit = 1'b0;
    for (int i = N_SEL - 1; i >= 0; i--)
      if (sel_all_i[i]) pbit = prot_vec_i[i];
  end

  always_comb begin
    src_d = SRC_ARRAY;
    if (special_i) begin
      case (key_i)
        3'b001:  src_d = any_pri ? SRC_ID : SRC_ZERO;
        3'b010:  src_d = (|sel_all_i) ? SRC_PROT : SRC_ZERO;
        default: src_d = SRC_ZERO;
      endcase
    end
    case (src_d)
      SRC_ARRAY: data_d = array_data_i;
      SRC_ID:    data_d = dev_id_i;
      SRC_PROT:  data_d = {7'd0, pbit};
      default:   data_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_o  <= SRC_ARRAY;
      data_o <= 8'h00;
    end else if (rd_strobe_i) begin
      src_o  <= src_d;
      data_o <= data_d;
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe_i |=> ($stable(data_o) && $stable(src_o)));
  a_r10_array_in_normal: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_i && !special_i) |=> (src_o == SRC_ARRAY));
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder #(
  parameter int N_PRI         = 8,
  parameter int N_SEC         = 4,
  parameter int TIMEOUT_TICKS = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [11:0]            bus_addr_i,
  input  logic [7:0]             bus_data_i,
  input  logic                   wr_strobe_i,
  input  logic                   rd_strobe_i,
  input  logic [N_PRI-1:0]       sel_pri_i,
  input  logic [N_SEC-1:0]       sel_sec_i,
  input  logic [N_PRI+N_SEC-1:0] prot_vec_i,
  input  logic [7:0]             dev_id_i,
  input  logic [7:0]             array_data_i,
  input  logic                   tick_i,
  output logic [1:0]             rd_src_o,
  output logic [7:0]             rd_data_o,
  output logic                   prog_start_o,
  output logic                   erase_start_o,
  output logic                   erase_chip_o,
  output logic                   suspend_o,
  output logic                   resume_o,
  output logic                   bypass_o,
  output logic                   tgt_sec_o
);
  localparam int N_SEL = N_PRI + N_SEC;

  logic wr_edge, busy, accept, timeout, special;
  logic [N_SEL-1:0] sel_all;

  assign sel_all = {sel_sec_i, sel_pri_i};

  fcmd_wr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .strobe_i(wr_strobe_i), .edge_o(wr_edge)
  );

  fcmd_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rst(rst), .busy_i(busy), .restart_i(accept),
    .tick_i(tick_i), .timeout_o(timeout)
  );

  fcmd_seq u_seq (
    .clk(clk), .rst(rst), .wr_i(wr_edge), .any_sel_i(|sel_all),
    .any_sec_i(|sel_sec_i), .addr_i(bus_addr_i), .data_i(bus_data_i),
    .timeout_i(timeout), .busy_o(busy), .accept_o(accept),
    .special_o(special), .prog_o(prog_start_o), .erase_o(erase_start_o),
    .erase_chip_o(erase_chip_o), .susp_o(suspend_o), .resume_o(resume_o),
    .bypass_o(bypass_o), .tgt_sec_o(tgt_sec_o)
  );

  fcmd_rd_mux #(.N_SEL(N_SEL), .N_PRI(N_PRI)) u_rd (
    .clk(clk), .rst(rst), .rd_strobe_i(rd_strobe_i), .special_i(special),
    .key_i({bus_addr_i[6], bus_addr_i[1], bus_addr_i[0]}),
    .sel_all_i(sel_all), .prot_vec_i(prot_vec_i), .dev_id_i(dev_id_i),
    .array_data_i(array_data_i), .src_o(rd_src_o), .data_o(rd_data_o)
  );
endmodule

// File: tb/fcmd_decoder_tb.sv
`timescale 1ns/1ps
module fcmd_decoder_tb_top;
  localparam int NP = 8, NS = 4, TO = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0] data = '0, dev_id = 8'hE7, arr = 8'h3C;
  logic wr = 1'b0, rd = 1'b0, tick = 1'b0;
  logic [NP-1:0] spri = '0;
  logic [NS-1:0] ssec = '0;
  logic [NP+NS-1:0] prot = 12'b0010_0000_0100;
  logic [1:0] src;
  logic [7:0] rdata;
  logic prog, era, chip, susp, resm, byp, tsec;
  int checks = 0, errors = 0;
  int n_prog = 0, n_era = 0, n_susp = 0, n_res = 0, n_byp = 0;

  always #2.5 clk = ~clk;

  fcmd_decoder #(.N_PRI(NP), .N_SEC(NS), .TIMEOUT_TICKS(TO)) dut_i (
    .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_data_i(data),
    .wr_strobe_i(wr), .rd_strobe_i(rd), .sel_pri_i(spri), .sel_sec_i(ssec),
    .prot_vec_i(prot), .dev_id_i(dev_id), .array_data_i(arr), .tick_i(tick),
    .rd_src_o(src), .rd_data_o(rdata), .prog_start_o(prog),
    .erase_start_o(era), .erase_chip_o(chip), .suspend_o(susp),
    .resume_o(resm), .bypass_o(byp), .tgt_sec_o(tsec)
  );

  always @(posedge clk) begin
    if (prog) n_prog++;
    if (era)  n_era++;
    if (susp) n_susp++;
    if (resm) n_res++;
    if (byp)  n_byp++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_sel(input logic [11:0] a, input logic [7:0] d,
                        input logic [NP-1:0] p, input logic [NS-1:0] s,
                        input int hold);
    @(negedge clk);
    addr = a; data = d; spri = p; ssec = s; wr = 1'b1;
    repeat (hold) @(negedge clk);
    wr = 1'b0;
    repeat (2) @(negedge clk);
    spri = '0; ssec = '0;
  endtask

  task automatic wrp(input logic [11:0] a, input logic [7:0] d);
    wr_sel(a, d, 8'h01, 4'h0, 4);
  endtask

  task automatic unlock();
    wrp(12'h555, 8'hAA);
    wrp(12'hAAA, 8'h55);
  endtask

  task automatic rd_at(input logic [11:0] a, input logic [NP-1:0] p,
                       input logic [NS-1:0] s);
    @(negedge clk);
    addr = a; spri = p; ssec = s; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    @(negedge clk);
    spri = '0; ssec = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 src", src, 0);
    chk("R1 data", rdata, 0);
    chk("R1 pulses", {prog, era, susp, resm, byp}, 0);
  endtask

  task automatic t_array_read();
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R10 array src", src, 0);
    chk("R10 array data", rdata, 8'h3C);
  endtask

  task automatic t_special_reads();
    unlock(); wrp(12'h555, 8'h90);
    rd_at(12'h881, 8'h01, 4'h0);
    chk("R8 id src", src, 1);
    chk("R8 id data", rdata, 8'hE7);
    rd_at(12'h001, 8'h00, 4'h2);
    chk("R8 secondary id src", src, 3);
    chk("R8 secondary id data", rdata, 0);
    rd_at(12'h002, 8'h04, 4'h0);
    chk("R9 protected src", src, 2);
    chk("R9 protected", rdata, 1);
    rd_at(12'h002, 8'h08, 4'h0);
    chk("R9 unprotected", rdata, 0);
    rd_at(12'h002, 8'h00, 4'h2);
    chk("R9 secondary protected", rdata, 1);
    rd_at(12'h041, 8'h01, 4'h0);
    chk("R10 other addr src", src, 3);
    chk("R10 other addr data", rdata, 0);
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R7 mode persists", src, 1);
    wrp(12'h123, 8'hF0);
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R6 lone F0 exits", src, 0);
  endtask

  task automatic t_preamble_reset();
    unlock(); wrp(12'h555, 8'h90);
    unlock(); wrp(12'h555, 8'hF0);
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R6 preamble F0 exits", src, 0);
  endtask

  task automatic t_wrong();
    wrp(12'h555, 8'hAA); wrp(12'hAAA, 8'h56); wrp(12'h555, 8'h90);
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R4 wrong data", src, 0);
    wrp(12'h555, 8'hAA); wrp(12'hAAB, 8'h55); wrp(12'h555, 8'h90);
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R2 wrong address", src, 0);
    unlock(); wrp(12'h555, 8'h90);
    wrp(12'h555, 8'h12);
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R4 stray write leaves special", src, 0);
  endtask

  task automatic t_nosel();
    wrp(12'h555, 8'hAA);
    wr_sel(12'h000, 8'h77, 8'h00, 4'h0, 4);
    wrp(12'hAAA, 8'h55);
    wr_sel(12'h555, 8'h13, 8'h00, 4'h0, 4);
    wrp(12'h555, 8'h90);
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R3 unselected writes ignored", src, 1);
    wrp(12'h000, 8'hF0);
  endtask

  task automatic t_timeout();
    unlock(); ticks(TO - 1); wrp(12'h555, 8'h90);
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R5 below limit", src, 1);
    wrp(12'h000, 8'hF0);
    unlock(); ticks(TO); wrp(12'h555, 8'h90);
    rd_at(12'h001, 8'h01, 4'h0);
    chk("R5 at limit aborts", src, 0);
  endtask

  task automatic t_program();
    int b = n_prog;
    unlock(); wrp(12'h555, 8'hA0);
    chk("R12 armed no pulse", n_prog, b);
    wr_sel(12'h3F0, 8'h5A, 8'h00, 4'h1, 20);
    chk("R14 program once", n_prog, b + 1);
    chk("R12 target secondary", tsec, 1);
  endtask

  task automatic t_erase();
    int b = n_era;
    unlock(); wrp(12'h555, 8'h80); unlock(); wrp(12'h100, 8'h30);
    chk("R13 sector erase", n_era, b + 1);
    chk("R13 sector flag", chip, 0);
    unlock(); wrp(12'h555, 8'h80); unlock(); wrp(12'h555, 8'h10);
    chk("R13 chip erase", n_era, b + 2);
    chk("R13 chip flag", chip, 1);
    chk("R12 target primary", tsec, 0);
  endtask

  task automatic t_misc_cmds();
    int bs = n_susp, br = n_res, bb = n_byp;
    unlock(); wrp(12'h000, 8'hB0);
    chk("R12 suspend", n_susp, bs + 1);
    unlock(); wrp(12'h000, 8'h30);
    chk("R12 resume", n_res, br + 1);
    unlock(); wrp(12'h000, 8'h20);
    chk("R12 bypass", n_byp, bb + 1);
  endtask

  task automatic t_rd_hold();
    rd_at(12'h000, 8'h01, 4'h0);
    arr = 8'h99;
    repeat (3) @(negedge clk);
    chk("R11 hold without strobe", rdata, 8'h3C);
    rd_at(12'h000, 8'h01, 4'h0);
    chk("R11 update on strobe", rdata, 8'h99);
    arr = 8'h3C;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_array_read();
    t_special_reads();
    t_preamble_reset();
    t_wrong();
    t_nosel();
    t_timeout();
    t_program();
    t_erase();
    t_misc_cmds();
    t_rd_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule